// File: doc/BRIEF.md
# Multi-Lane NCO Phase Core

This block is the phase engine of a numerically controlled oscillator with three independent lanes. Each lane keeps a running phase accumulator, a frequency step and a phase offset. On every clock the accumulator grows by the frequency step, at full clock rate. The lane reports the sum of accumulator and offset as its output phase word. A downstream waveform stage (not part of this block) turns that word into samples.

A per-lane update-mode bit decides what a phase offset write does. In absolute mode the write zeroes the accumulator, so the output restarts at exactly the written offset and then advances at the current frequency. In continuous mode the accumulator keeps running and only the offset is replaced. The output therefore jumps by the difference between the new and old offsets and stays coherent with the carrier. The mode bits sit in a small register loaded by a strobe, and they come out of reset in absolute mode.

Top module: `nco_phase_core`

## Requirements
- R1: A synchronous active-high reset zeroes every accumulator, offset and frequency step, so all output phases read 0. It also sets every mode bit to 1 (absolute), and reset takes priority over any write in the same cycle.
- R2: While no writes occur, each lane's output phase grows by that lane's frequency step on every clock.
- R3: A frequency-only write changes the step from the following cycle. The increment applied at the write edge still uses the old step.
- R4: When mode bit i is 1, an offset write to lane i zeroes its accumulator. The output right after that edge equals the written offset, and it then advances by the frequency step.
- R5: When mode bit i is 0, an offset write to lane i leaves the accumulator running. The output right after that edge equals the previous output, plus the step, plus (new offset minus old offset).
- R6: A frequency-only write never zeroes the accumulator, whatever the mode bit.
- R7: A frequency write and an offset write to the same lane in one cycle both take effect together. The accumulator advances by the new step from the next cycle.
- R8: Writes to one lane leave the other lanes' outputs unaffected.
- R9: Mode bits load from `mode_bits` only when `mode_we` is 1. Bit i controls lane i, and 1 means absolute and 0 means continuous. Without the strobe, `mode_bits` has no effect.
- R10: All phase arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_we | input | 3 | Per-lane frequency write strobe |
| freq_word | input | 96 | Frequency steps, lane i in bits [32i+31:32i] |
| ofs_we | input | 3 | Per-lane phase offset write strobe |
| ofs_word | input | 96 | Phase offsets, lane i in bits [32i+31:32i] |
| mode_we | input | 1 | Mode register load strobe |
| mode_bits | input | 3 | Mode bits, bit i for lane i (1 absolute, 0 continuous) |
| phase_out | output | 96 | Output phase words, lane i in bits [32i+31:32i] |

## Verification
Offset writes are applied in both modes to a lane that has been running for a while. This separates a zeroed accumulator from one that kept its carrier: absolute mode lands exactly on the offset, while continuous mode lands on the old phase shifted by the offset difference. Frequency-only writes and combined frequency-plus-offset writes show which step governs the edge of the write and which governs the cycle after it. A large step drives the sum past 2^32 to expose missing wrap-around. Runs on several lanes with different modes, plus a reset that arrives together with active writes, show lane isolation and the reset defaults of the mode bits.

// File: rtl/nco_phase_pkg.sv
package nco_phase_pkg;

    localparam int LANES_DEF   = 3;
    localparam int PHASE_W_DEF = 32;

    typedef enum logic {
        UPD_CONTINUOUS = 1'b0,
        UPD_ABSOLUTE   = 1'b1
    } upd_mode_e;

    typedef enum logic [1:0] {
        ACC_RUN   = 2'd0,
        ACC_ZERO  = 2'd1
    } acc_action_e;

    // Choose what the accumulator does at the coming edge.
    function automatic acc_action_e pick_action(input logic ofs_write,
                                                input upd_mode_e mode);
        if (ofs_write && (mode == UPD_ABSOLUTE))
            return ACC_ZERO;
        return ACC_RUN;
    endfunction

endpackage

// File: rtl/nco_mode_reg.sv
module nco_mode_reg
    import nco_phase_pkg::*;
#(
    parameter int NUM_LANES = LANES_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [NUM_LANES-1:0] bits_in,
    output logic [NUM_LANES-1:0] mode_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '1;
        else if (load)
            mode_q <= bits_in;
    end

endmodule

// File: rtl/nco_phase_lane.sv
module nco_phase_lane
    import nco_phase_pkg::*;
#(
    parameter int PHASE_W = PHASE_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               freq_we,
    input  logic [PHASE_W-1:0] freq_word,
    input  logic               ofs_we,
    input  logic [PHASE_W-1:0] ofs_word,
    input  upd_mode_e          mode,
    output logic [PHASE_W-1:0] phase,
    output logic [PHASE_W-1:0] acc_o,
    output logic [PHASE_W-1:0] ofs_o,
    output logic [PHASE_W-1:0] frq_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
        logic [PHASE_W-1:0] ofs;
        logic [PHASE_W-1:0] frq;
    } lane_state_t;

    lane_state_t st_q, st_d;
    acc_action_e act;

    always_comb begin
        act  = pick_action(ofs_we, mode);
        st_d = st_q;
        unique case (act)
            ACC_ZERO: st_d.acc = '0;
            default:  st_d.acc = st_q.acc + st_q.frq;
        endcase
        if (ofs_we)
            st_d.ofs = ofs_word;
        if (freq_we)
            st_d.frq = freq_word;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign phase = st_q.acc + st_q.ofs;
    assign acc_o = st_q.acc;
    assign ofs_o = st_q.ofs;
    assign frq_o = st_q.frq;

endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
    import nco_phase_pkg::*;
#(
    parameter int NUM_LANES = LANES_DEF,
    parameter int PHASE_W   = PHASE_W_DEF
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_LANES-1:0]           freq_we,
    input  logic [NUM_LANES*PHASE_W-1:0]   freq_word,
    input  logic [NUM_LANES-1:0]           ofs_we,
    input  logic [NUM_LANES*PHASE_W-1:0]   ofs_word,
    input  logic                           mode_we,
    input  logic [NUM_LANES-1:0]           mode_bits,
    output logic [NUM_LANES*PHASE_W-1:0]   phase_out
);

    localparam int BUS_W = NUM_LANES * PHASE_W;

    logic [NUM_LANES-1:0] mode_q;
    logic [BUS_W-1:0]     lane_acc;
    logic [BUS_W-1:0]     lane_ofs;
    logic [BUS_W-1:0]     lane_frq;

    nco_mode_reg #(.NUM_LANES(NUM_LANES)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .load    (mode_we),
        .bits_in (mode_bits),
        .mode_q  (mode_q)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        nco_phase_lane #(.PHASE_W(PHASE_W)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .freq_we   (freq_we[i]),
            .freq_word (freq_word[i*PHASE_W +: PHASE_W]),
            .ofs_we    (ofs_we[i]),
            .ofs_word  (ofs_word[i*PHASE_W +: PHASE_W]),
            .mode      (upd_mode_e'(mode_q[i])),
            .phase     (phase_out[i*PHASE_W +: PHASE_W]),
            .acc_o     (lane_acc[i*PHASE_W +: PHASE_W]),
            .ofs_o     (lane_ofs[i*PHASE_W +: PHASE_W]),
            .frq_o     (lane_frq[i*PHASE_W +: PHASE_W])
        );
    end

endmodule

// File: rtl/nco_phase_checker.sv
module nco_phase_checker #(
    parameter int NUM_LANES = 3,
    parameter int PHASE_W   = 32
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_LANES-1:0]         freq_we,
    input logic [NUM_LANES-1:0]         ofs_we,
    input logic [NUM_LANES*PHASE_W-1:0] ofs_word,
    input logic                         mode_we,
    input logic [NUM_LANES-1:0]         mode_q,
    input logic [NUM_LANES*PHASE_W-1:0] lane_acc,
    input logic [NUM_LANES*PHASE_W-1:0] lane_frq,
    input logic [NUM_LANES*PHASE_W-1:0] phase_out
);

    logic [1:0] cyc;
    logic       started;

    always_ff @(posedge clk) begin
        started <= 1'b1;
        if (rst)
            cyc <= '0;
        else if (cyc != 2'd3)
            cyc <= cyc + 2'd1;
    end

    // R1: after a reset edge, outputs are zero and all lanes are absolute.
    p_reset_state_r1: assert property (@(posedge clk)
        (started === 1'b1 && $past(rst)) |-> (mode_q == '1 && phase_out == '0));

    // R9: mode register changes only on the load strobe.
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cyc != 2'd0 && !mode_we) |=> $stable(mode_q));

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_chk
        // R2: with no writes, the per-cycle increment stays constant.
        p_steady_step_r2: assert property (@(posedge clk) disable iff (rst)
            (cyc == 2'd3 && !$past(ofs_we[i]) && !$past(ofs_we[i], 2)
             && !$past(freq_we[i], 2))
            |-> (phase_out[i*PHASE_W +: PHASE_W] - $past(phase_out[i*PHASE_W +: PHASE_W]))
                == ($past(phase_out[i*PHASE_W +: PHASE_W])
                    - $past(phase_out[i*PHASE_W +: PHASE_W], 2)));

        // R4: absolute-mode offset write lands exactly on the offset.
        p_abs_load_r4: assert property (@(posedge clk) disable iff (rst)
            (ofs_we[i] && mode_q[i])
            |=> phase_out[i*PHASE_W +: PHASE_W] == $past(ofs_word[i*PHASE_W +: PHASE_W]));

        // R5: continuous-mode offset write keeps the running accumulator.
        p_rel_load_r5: assert property (@(posedge clk) disable iff (rst)
            (ofs_we[i] && !mode_q[i])
            |=> phase_out[i*PHASE_W +: PHASE_W]
                == $past(lane_acc[i*PHASE_W +: PHASE_W]) + $past(lane_frq[i*PHASE_W +: PHASE_W])
                   + $past(ofs_word[i*PHASE_W +: PHASE_W]));

        // R6: frequency-only write never zeroes the accumulator.
        p_freq_noclr_r6: assert property (@(posedge clk) disable iff (rst)
            (freq_we[i] && !ofs_we[i])
            |=> phase_out[i*PHASE_W +: PHASE_W]
                == $past(phase_out[i*PHASE_W +: PHASE_W]) + $past(lane_frq[i*PHASE_W +: PHASE_W]));
    end

endmodule

bind nco_phase_core nco_phase_checker #(
    .NUM_LANES (NUM_LANES),
    .PHASE_W   (PHASE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .freq_we   (freq_we),
    .ofs_we    (ofs_we),
    .ofs_word  (ofs_word),
    .mode_we   (mode_we),
    .mode_q    (mode_q),
    .lane_acc  (lane_acc),
    .lane_frq  (lane_frq),
    .phase_out (phase_out)
);

// File: tb/nco_phase_core_bench.sv
module nco_phase_core_bench;

    localparam int N  = 3;
    localparam int W  = 32;
    localparam int NV = 18;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   freq_we = '0;
    logic [N*W-1:0] freq_word = '0;
    logic [N-1:0]   ofs_we = '0;
    logic [N*W-1:0] ofs_word = '0;
    logic           mode_we = 1'b0;
    logic [N-1:0]   mode_bits = '0;
    logic [N*W-1:0] phase_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    nco_phase_core u_nco_phase_core (
        .clk       (clk),
        .rst       (rst),
        .freq_we   (freq_we),
        .freq_word (freq_word),
        .ofs_we    (ofs_we),
        .ofs_word  (ofs_word),
        .mode_we   (mode_we),
        .mode_bits (mode_bits),
        .phase_out (phase_out)
    );

    typedef struct packed {
        logic          fw;
        logic [W-1:0]  f;
        logic          ow;
        logic [W-1:0]  o;
        logic          mw;
        logic [N-1:0]  m;
        logic [W-1:0]  exp;
    } vec_t;

    // Lane 0 stimulus; expected output phase after the edge.
    localparam vec_t TBL [NV] = '{
        '{1'b1, 32'd10,         1'b0, 32'd0,    1'b0, 3'b000, 32'd0},    // R3
        '{1'b0, 32'd0,          1'b0, 32'd0,    1'b0, 3'b000, 32'd10},   // R2
        '{1'b0, 32'd0,          1'b0, 32'd0,    1'b0, 3'b000, 32'd20},   // R2
        '{1'b0, 32'd0,          1'b1, 32'd100,  1'b0, 3'b000, 32'd100},  // R4
        '{1'b0, 32'd0,          1'b0, 32'd0,    1'b0, 3'b000, 32'd110},  // R4
        '{1'b0, 32'd0,          1'b0, 32'd0,    1'b1, 3'b000, 32'd120},  // R9
        '{1'b0, 32'd0,          1'b1, 32'd1000, 1'b0, 3'b000, 32'd1030}, // R5
        '{1'b0, 32'd0,          1'b0, 32'd0,    1'b0, 3'b000, 32'd1040}, // R5
        '{1'b1, 32'd5,          1'b1, 32'd500,  1'b0, 3'b000, 32'd550},  // R7
        '{1'b0, 32'd0,          1'b0, 32'd0,    1'b0, 3'b000, 32'd555},  // R7
        '{1'b1, 32'd7,          1'b0, 32'd0,    1'b0, 3'b000, 32'd560},  // R6
        '{1'b0, 32'd0,          1'b0, 32'd0,    1'b0, 3'b000, 32'd567},  // R3
        '{1'b0, 32'd0,          1'b0, 32'd0,    1'b1, 3'b001, 32'd574},  // R9
        '{1'b1, 32'd3,          1'b1, 32'd200,  1'b0, 3'b000, 32'd200},  // R7
        '{1'b0, 32'd0,          1'b0, 32'd0,    1'b0, 3'b000, 32'd203},  // R2
        '{1'b1, 32'hFFFF_FFF0,  1'b0, 32'd0,    1'b0, 3'b000, 32'd206},  // R6
        '{1'b0, 32'd0,          1'b0, 32'd0,    1'b0, 3'b000, 32'h0000_00BE}, // R10
        '{1'b0, 32'd0,          1'b0, 32'd0,    1'b0, 3'b000, 32'h0000_00AE}  // R10
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ph(input int lane);
        return phase_out[lane*W +: W];
    endfunction

    task automatic idle();
        freq_we = '0;
        ofs_we  = '0;
        mode_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        // R1: reset state
        for (int i = 0; i < N; i++) chk("R1 reset phase", ph(i), '0);
        rst = 1'b0;

        // Vector table on lane 0
        for (int v = 0; v < NV; v++) begin
            freq_we[0]       = TBL[v].fw;
            freq_word[0 +: W] = TBL[v].f;
            ofs_we[0]        = TBL[v].ow;
            ofs_word[0 +: W] = TBL[v].o;
            mode_we          = TBL[v].mw;
            mode_bits        = TBL[v].m;
            tick();
            chk($sformatf("R2-R10 table row %0d", v), ph(0), TBL[v].exp);
            idle();
        end

        // R1: reset wins over simultaneous writes; mode returns to absolute
        rst       = 1'b1;
        freq_we   = '1;
        freq_word = {N{32'd5}};
        ofs_we    = '1;
        ofs_word  = {N{32'd77}};
        mode_we   = 1'b1;
        mode_bits = 3'b000;
        tick();
        tick();
        for (int i = 0; i < N; i++) chk("R1 reset over writes", ph(i), '0);
        rst = 1'b0;
        idle();

        // R9: mode_bits without strobe are ignored (held at 000 here)
        freq_we[0] = 1'b1;
        freq_word[0 +: W] = 32'd9;
        tick();
        chk("R3 step after freq write", ph(0), 32'd0);
        idle();
        tick();
        chk("R2 advance", ph(0), 32'd9);
        ofs_we[0] = 1'b1;
        ofs_word[0 +: W] = 32'd50;
        tick();
        chk("R1 R9 default absolute kept", ph(0), 32'd50);
        idle();

        // R8: lane independence with mixed modes
        freq_we = 3'b110;
        freq_word[1*W +: W] = 32'd2;
        freq_word[2*W +: W] = 32'd3;
        tick();
        idle();
        mode_we   = 1'b1;
        mode_bits = 3'b101;
        tick();
        idle();
        ofs_we[1] = 1'b1;
        ofs_word[1*W +: W] = 32'd1000;
        tick();
        chk("R5 lane1 continuous", ph(1), 32'd1004);
        chk("R8 lane2 untouched", ph(2), 32'd6);
        idle();
        ofs_we[2] = 1'b1;
        ofs_word[2*W +: W] = 32'd7;
        tick();
        chk("R4 lane2 absolute", ph(2), 32'd7);
        chk("R8 lane1 untouched", ph(1), 32'd1006);
        chk("R8 lane0 untouched", ph(0), 32'd86);
        idle();

        finish_run();
    end

endmodule